// File: doc/BRIEF.md
# Unified Bit Scan and Zero Count Unit

This execution-stage datapath finds the highest or lowest set bit of an operand. It returns the result either as a bit index or as a count of zeros. Four operations share one priority-encoder core:

- reverse scan: index of the most significant set bit;
- forward scan: index of the least significant set bit;
- leading-zero count;
- trailing-zero count.

A decoder supplies the operation as two inputs. One selects the reverse-family or forward-family opcode. The other shows whether a repeat prefix is present. The prefix turns the index-returning scan into its counting twin.

A mode input selects a 32-bit or a 64-bit operand. In 32-bit mode the upper half of the source is disregarded, and results are zero-extended. The two families treat a zero operand differently:

- the counts return the operand width and raise a carry flag;
- the scans raise the zero flag, mark the result undefined, and pass through the previous destination value supplied by the caller.

All outputs are registered and appear one cycle after an accepted input.

Top module: `bitscan_unit`

## Requirements
- R1: With opc_fwd_i=0 and rep_pfx_i=0 (reverse scan), a nonzero operand yields the index of its most significant set bit (0x11AA00BB gives 28).
- R2: With opc_fwd_i=1 and rep_pfx_i=0 (forward scan), a nonzero operand yields the index of its least significant set bit.
- R3: With opc_fwd_i=0 and rep_pfx_i=1, the result is the leading-zero count, i.e. width-1 minus the reverse-scan index (0x11AA00BB gives 3 in 32-bit mode and 35 in 64-bit mode).
- R4: With opc_fwd_i=1 and rep_pfx_i=1, the result is the trailing-zero count, equal to the forward-scan index for a nonzero operand.
- R5: For a zero operand, both counts return the active width (32 or 64), set cf_o=1, and clear zf_o and undef_o.
- R6: For a zero operand, both scans set zf_o=1 and undef_o=1, clear cf_o, and return dst_old_i unchanged on result_o.
- R7: For the counts, zf_o=1 exactly when the count is 0, and cf_o=0 for a nonzero operand.
- R8: For the scans, a nonzero operand gives zf_o=0, cf_o=0 and undef_o=0.
- R9: With wide_i=0, src_i bits 63:32 have no effect, and defined results have bits 63:32 equal to 0; wide_i=1 selects 64-bit width.
- R10: out_valid_o is 1 exactly in the cycle after in_valid_i=1. result_o and the flags are captured only when in_valid_i=1 and hold otherwise.
- R11: While rst_ni=0, out_valid_o, result_o, zf_o, cf_o and undef_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand and operation are valid this cycle |
| opc_fwd_i | input | 1 | 0 = reverse-family opcode, 1 = forward-family opcode |
| rep_pfx_i | input | 1 | Repeat prefix present; selects the count variant |
| wide_i | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| src_i | input | 64 | Source operand |
| dst_old_i | input | 64 | Previous destination value, returned when a scan is undefined |
| out_valid_o | output | 1 | Registered result is new this cycle |
| result_o | output | 64 | Index, count, or passed-through destination |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag (count of a zero operand) |
| undef_o | output | 1 | Scan of a zero operand; result is the old destination |

## Verification
Any fault in the one shared encoder, the bit-reversal mux or the width select shows up at the ports one cycle after the input is accepted. It appears as a result off by the reflected index, by 32, or by one, together with flags that disagree with the result. The vector table therefore pairs each operand with both members of an opcode pair and with both widths, so that a crossed select shows up as a different value. A register-enable or reset fault shows up as a value that does not hold during idle cycles, or as nonzero outputs while reset is held.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

   // Operation code: bit 1 = count variant (prefix), bit 0 = forward family
   typedef enum logic [1:0] {
      BSU_OP_RSCAN = 2'b00,
      BSU_OP_FSCAN = 2'b01,
      BSU_OP_LZCNT = 2'b10,
      BSU_OP_TZCNT = 2'b11
   } bsu_op_e;

   typedef struct packed {
      logic zf;
      logic cf;
      logic undef;
   } bsu_flags_t;

   function automatic bsu_op_e bsu_decode(input logic fwd, input logic pfx);
      return bsu_op_e'({pfx, fwd});
   endfunction

   function automatic logic bsu_is_count(input bsu_op_e op);
      return op[1];
   endfunction

   function automatic logic bsu_is_fwd(input bsu_op_e op);
      return op[0];
   endfunction

endpackage

// File: rtl/bsu_operand_prep.sv
module bsu_operand_prep #(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic              wide_i,
   input  logic              fwd_i,
   output logic [DATA_W-1:0] enc_vec_o,
   output logic              nonzero_o
);

   logic [DATA_W-1:0] masked;
   logic [DATA_W-1:0] mirrored;

   // Lanes above the narrow width only count in wide mode
   for (genvar b = 0; b < DATA_W; b++) begin : g_lane
      if (b < NARROW_W) begin : g_low
         assign masked[b] = src_i[b];
      end else begin : g_high
         assign masked[b] = src_i[b] & wide_i;
      end
      assign mirrored[DATA_W-1-b] = masked[b];
   end

   // Mirroring turns the lowest set bit into the highest for the shared encoder
   assign enc_vec_o = fwd_i ? mirrored : masked;
   assign nonzero_o = |masked;

endmodule

// File: rtl/bsu_msb_enc.sv
module bsu_msb_enc #(
   parameter int W     = 64,
   parameter bit SPLIT = 1'b1,
   localparam int IDX_W = $clog2(W)
) (
   input  logic [W-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);

   localparam int HALF   = W / 2;
   localparam int HIDX_W = IDX_W - 1;

   if (SPLIT) begin : g_split
      logic [HIDX_W-1:0] lo_idx, hi_idx;
      logic              lo_any, hi_any;

      always_comb begin
         lo_idx = '0;
         lo_any = 1'b0;
         for (int i = 0; i < HALF; i++) begin
            if (vec_i[i]) begin
               lo_idx = HIDX_W'(i);
               lo_any = 1'b1;
            end
         end
      end

      always_comb begin
         hi_idx = '0;
         hi_any = 1'b0;
         for (int i = 0; i < HALF; i++) begin
            if (vec_i[HALF+i]) begin
               hi_idx = HIDX_W'(i);
               hi_any = 1'b1;
            end
         end
      end

      assign idx_o = hi_any ? {1'b1, hi_idx} : {1'b0, lo_idx};
      assign any_o = hi_any | lo_any;
   end else begin : g_linear
      always_comb begin
         idx_o = '0;
         for (int i = 0; i < W; i++) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
         end
      end
      assign any_o = |vec_i;
   end

endmodule

// File: rtl/bsu_result_form.sv
module bsu_result_form
   import bsu_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   localparam int IDX_W   = $clog2(DATA_W),
   localparam int CNT_W   = IDX_W + 1
) (
   input  bsu_op_e           op_i,
   input  logic              wide_i,
   input  logic              nonzero_i,
   input  logic [IDX_W-1:0]  enc_idx_i,
   input  logic [DATA_W-1:0] dst_old_i,
   output logic [DATA_W-1:0] result_o,
   output bsu_flags_t        flags_o
);

   localparam logic [CNT_W-1:0] FULL_C   = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] NARROW_C = CNT_W'(NARROW_W);
   localparam logic [CNT_W-1:0] TOP_C    = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0] pos, width_v, count;
   logic             fwd, cnt;

   assign fwd     = bsu_is_fwd(op_i);
   assign cnt     = bsu_is_count(op_i);
   assign width_v = wide_i ? FULL_C : NARROW_C;
   // Undo the mirroring applied for the forward family
   assign pos     = fwd ? (TOP_C - {1'b0, enc_idx_i}) : {1'b0, enc_idx_i};

   always_comb begin
      if (!nonzero_i)  count = width_v;
      else if (fwd)    count = pos;
      else             count = width_v - 1'b1 - pos;
   end

   always_comb begin
      flags_o = '0;
      if (cnt) begin
         result_o      = DATA_W'(count);
         flags_o.cf    = ~nonzero_i;
         flags_o.zf    = (count == '0);
      end else if (!nonzero_i) begin
         result_o      = dst_old_i;
         flags_o.zf    = 1'b1;
         flags_o.undef = 1'b1;
      end else begin
         result_o      = DATA_W'(pos);
      end
   end

endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
   import bsu_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int NARROW_W  = 32,
   parameter bit ENC_SPLIT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic              opc_fwd_i,
   input  logic              rep_pfx_i,
   input  logic              wide_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_old_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] result_o,
   output logic              zf_o,
   output logic              cf_o,
   output logic              undef_o
);

   localparam int IDX_W = $clog2(DATA_W);

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("bitscan_unit: DATA_W must be a power of two of at least 8");
   end
   if (NARROW_W < 2 || NARROW_W > DATA_W) begin : g_bad_narrow
      $error("bitscan_unit: NARROW_W must lie in 2..DATA_W");
   end

   bsu_op_e           op;
   logic [DATA_W-1:0] enc_vec;
   logic              nonzero;
   logic              enc_any;
   logic [IDX_W-1:0]  enc_idx;
   logic [DATA_W-1:0] res_d;
   bsu_flags_t        flags_d;

   assign op = bsu_decode(opc_fwd_i, rep_pfx_i);

   bsu_operand_prep #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_prep (
      .src_i     (src_i),
      .wide_i    (wide_i),
      .fwd_i     (bsu_is_fwd(op)),
      .enc_vec_o (enc_vec),
      .nonzero_o (nonzero)
   );

   bsu_msb_enc #(.W(DATA_W), .SPLIT(ENC_SPLIT)) u_enc (
      .vec_i (enc_vec),
      .idx_o (enc_idx),
      .any_o (enc_any)
   );

   bsu_result_form #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_form (
      .op_i      (op),
      .wide_i    (wide_i),
      .nonzero_i (nonzero & enc_any),
      .enc_idx_i (enc_idx),
      .dst_old_i (dst_old_i),
      .result_o  (res_d),
      .flags_o   (flags_d)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         result_o    <= '0;
         zf_o        <= 1'b0;
         cf_o        <= 1'b0;
         undef_o     <= 1'b0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            result_o <= res_d;
            zf_o     <= flags_d.zf;
            cf_o     <= flags_d.cf;
            undef_o  <= flags_d.undef;
         end
      end
   end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              in_valid_i,
   input logic              opc_fwd_i,
   input logic              rep_pfx_i,
   input logic              wide_i,
   input logic [DATA_W-1:0] src_i,
   input logic              out_valid_o,
   input logic [DATA_W-1:0] result_o,
   input logic              zf_o,
   input logic              cf_o,
   input logic              undef_o
);

   localparam logic [DATA_W-1:0] ONE_C = DATA_W'(1);

   assert_rscan_index_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && !opc_fwd_i && !rep_pfx_i && wide_i && (src_i != '0)
      |=> (($past(src_i) >> result_o) == ONE_C));

   assert_fscan_index_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i && opc_fwd_i && !rep_pfx_i && wide_i && (src_i != '0)
      |=> ((($past(src_i) >> result_o) & ONE_C) == ONE_C)
          && (($past(src_i) & ((ONE_C << result_o) - ONE_C)) == '0));

   assert_count_zero_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && cf_o
      |-> !zf_o && !undef_o
          && (result_o == DATA_W'(DATA_W) || result_o == DATA_W'(NARROW_W)));

   assert_scan_undef_flags_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && undef_o |-> zf_o && !cf_o);

   assert_count_zf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && zf_o && !undef_o |-> result_o == '0);

   assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);

   assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o && $stable(result_o));

endmodule

bind bitscan_unit bsu_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_bsu_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .in_valid_i  (in_valid_i),
   .opc_fwd_i   (opc_fwd_i),
   .rep_pfx_i   (rep_pfx_i),
   .wide_i      (wide_i),
   .src_i       (src_i),
   .out_valid_o (out_valid_o),
   .result_o    (result_o),
   .zf_o        (zf_o),
   .cf_o        (cf_o),
   .undef_o     (undef_o)
);

// File: tb/bitscan_unit_tb_top.sv
module bitscan_unit_tb_top;

   localparam logic [63:0] DST = 64'h0123_4567_89AB_CDEF;

   typedef struct packed {
      logic        fwd;
      logic        pfx;
      logic        wide;
      logic [63:0] src;
      logic [63:0] res;
      logic        zf;
      logic        cf;
      logic        ud;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 1'b0, 64'h0000_0000_11AA_00BB, 64'd28,  1'b0, 1'b0, 1'b0}, // R1
      '{1'b0, 1'b1, 1'b0, 64'h0000_0000_11AA_00BB, 64'd3,   1'b0, 1'b0, 1'b0}, // R3
      '{1'b0, 1'b1, 1'b1, 64'h0000_0000_11AA_00BB, 64'd35,  1'b0, 1'b0, 1'b0}, // R3
      '{1'b1, 1'b0, 1'b0, 64'h0000_0000_11AA_00BB, 64'd0,   1'b0, 1'b0, 1'b0}, // R2 R8
      '{1'b1, 1'b1, 1'b0, 64'h0000_0000_11AA_00BB, 64'd0,   1'b1, 1'b0, 1'b0}, // R4 R7
      '{1'b1, 1'b0, 1'b1, 64'h0000_0100_0000_0000, 64'd40,  1'b0, 1'b0, 1'b0}, // R2
      '{1'b1, 1'b1, 1'b1, 64'h0000_0100_0000_0000, 64'd40,  1'b0, 1'b0, 1'b0}, // R4
      '{1'b0, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd63,  1'b0, 1'b0, 1'b0}, // R1
      '{1'b0, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd0,   1'b1, 1'b0, 1'b0}, // R7
      '{1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0000, 64'd32,  1'b0, 1'b1, 1'b0}, // R5
      '{1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_0000, 64'd64,  1'b0, 1'b1, 1'b0}, // R5
      '{1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0000, DST,     1'b1, 1'b0, 1'b1}, // R6
      '{1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_0000, DST,     1'b1, 1'b0, 1'b1}, // R6
      '{1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'd32,  1'b0, 1'b1, 1'b0}, // R9
      '{1'b0, 1'b0, 1'b0, 64'hF000_0000_0000_0010, 64'd4,   1'b0, 1'b0, 1'b0}, // R9
      '{1'b1, 1'b1, 1'b0, 64'h0000_0001_0000_0000, 64'd32,  1'b0, 1'b1, 1'b0}, // R9
      '{1'b1, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'd31,  1'b0, 1'b0, 1'b0}, // R2
      '{1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0001, 64'd31,  1'b0, 1'b0, 1'b0}, // R3
      '{1'b1, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd63,  1'b0, 1'b0, 1'b0}, // R4
      '{1'b0, 1'b0, 1'b1, 64'h0000_0001_0000_0000, 64'd32,  1'b0, 1'b0, 1'b0}  // R1
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        opc_fwd = 1'b0;
   logic        rep_pfx = 1'b0;
   logic        wide = 1'b0;
   logic [63:0] src = '0;
   logic [63:0] dst_old = DST;
   logic        out_valid;
   logic [63:0] result;
   logic        zf, cf, undef_f;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bitscan_unit dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .in_valid_i  (in_valid),
      .opc_fwd_i   (opc_fwd),
      .rep_pfx_i   (rep_pfx),
      .wide_i      (wide),
      .src_i       (src),
      .dst_old_i   (dst_old),
      .out_valid_o (out_valid),
      .result_o    (result),
      .zf_o        (zf),
      .cf_o        (cf),
      .undef_o     (undef_f)
   );

   task automatic check(input string tag, input logic [67:0] act, input logic [67:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      in_valid = 1'b1;
      opc_fwd  = v.fwd;
      rep_pfx  = v.pfx;
      wide     = v.wide;
      src      = v.src;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 reset", {out_valid, result, zf, cf, undef_f}, 68'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk; outputs sampled one cycle after the accepting edge
      for (int k = 0; k < NV; k++) begin
         apply(VECS[k]);
         check($sformatf("R10 vector %0d valid", k), {67'h0, out_valid}, 68'h1);
         check($sformatf("R1-R9 vector %0d", k), {out_valid, result, zf, cf, undef_f},
               {1'b1, VECS[k].res, VECS[k].zf, VECS[k].cf, VECS[k].ud});
      end

      // R10: idle cycle with changed inputs leaves outputs held
      opc_fwd = 1'b1;
      rep_pfx = 1'b1;
      src     = 64'h0000_0000_0000_0010;
      @(negedge clk);
      check("R10 idle hold", {out_valid, result, zf, cf, undef_f},
            {1'b0, 64'd32, 1'b0, 1'b0, 1'b0});

      // R6: old destination comes from dst_old_i at accept time
      dst_old = 64'hFEED_0000_0000_BEEF;
      apply('{1'b0, 1'b0, 1'b1, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0});
      check("R6 dst passthrough", {out_valid, result, zf, cf, undef_f},
            {1'b1, 64'hFEED_0000_0000_BEEF, 1'b1, 1'b0, 1'b1});

      // R9: only upper bits set, 32-bit forward scan is undefined
      apply('{1'b1, 1'b0, 1'b0, 64'hAAAA_0000_0000_0000, 64'h0, 1'b0, 1'b0, 1'b0});
      check("R9 upper ignored scan", {out_valid, result, zf, cf, undef_f},
            {1'b1, 64'hFEED_0000_0000_BEEF, 1'b1, 1'b0, 1'b1});

      // R10: back-to-back inputs, each result one cycle later
      @(negedge clk);
      in_valid = 1'b1; opc_fwd = 1'b0; rep_pfx = 1'b0; wide = 1'b1;
      src = 64'h0000_0000_0000_0100;
      @(negedge clk);
      check("R10 b2b first", {out_valid, result}, {1'b1, 64'd8});
      opc_fwd = 1'b0; rep_pfx = 1'b1; src = 64'h0000_0000_0000_0100;
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 b2b second", {out_valid, result}, {1'b1, 64'd55});

      // R11: reset mid-run clears registered state
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 reset again", {out_valid, result, zf, cf, undef_f}, 68'h0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule